// File: doc/BRIEF.md
# PCI Host Bridge Control Register Slave

This block is the register front end of a PCI host bridge. A host processor reaches it over a simple valid/ready register bus that carries 32-bit words. Each access is decoded into one of several areas:

- a local 64-word configuration header that describes the bridge itself;
- a configuration address register;
- a memory base register and an I/O base register, each keeping only its implemented bits;
- an indirect configuration data port.

An access to the data port does not complete inside the block. It becomes a request on a downstream configuration-transaction port, carrying the latched configuration address. The register bus stays stalled until the downstream side acknowledges. The block also drives the base of a 256 KiB I/O translation window, taken from the I/O base register.

An access completes on the rising edge where `req_valid` and `req_ready` are both high. A one-cycle response (`rsp_valid`, `rsp_err`, `rsp_rdata`) follows on the next cycle. The requester must hold its request stable while `req_ready` is low.

Top module: `pcib_regif`

## Requirements
- R1: Byte offsets 0x000 to 0x0FC address the local header, one 32-bit word per offset. A write replaces the stored word and a read returns it. After reset, the word at 0x000 reads {DEVICE_ID, VENDOR_ID}, with the vendor ID in bits 15:0, and every header word above 0x004 reads zero.
- R2: After reset, the header word at 0x004 reads 0x0290_0080. The command half (bits 15:0) holds only bit 7. The status half (bits 31:16) holds bit 4, bit 7 and bits 10:9 = 01.
- R3: Offset 0x1C0 is the configuration address register. It keeps all 32 written bits and resets to zero.
- R4: Offset 0x1C4 is the memory base register. A write keeps only bits 31:24 and bit 0 (mask 0xFF00_0001), and the other bits read zero. It resets to zero.
- R5: Offset 0x1C8 is the I/O base register, masked with 0xFFFC_0001 on write. `io_xlate_base` always equals this register with bits 17:0 cleared. Both reset to zero, and `io_xlate_base` changes only through an accepted write.
- R6: An access to offset 0x220 raises `cfg_req` on the cycle after the request is presented. `cfg_req` holds, with stable `cfg_addr`, `cfg_we` and `cfg_wdata`, until `cfg_ack`. `cfg_addr` equals the configuration address register. For a write, `cfg_we` is 1 and `cfg_wdata` carries the written data. `req_ready` stays low until the cycle in which `cfg_ack` is high.
- R7: A read at offset 0x220 returns the `cfg_rdata` value that is present in the `cfg_ack` cycle. For a read, `cfg_we` is 0.
- R8: A read of any other offset below 0x400 returns zero. A write to such an offset changes no register and no output.
- R9: An access with `req_be` not equal to 4'hF, or with `req_addr[1:0]` non-zero, is accepted at once. It gives `rsp_err` = 1 with zero data, changes no state and raises no `cfg_req`.
- R10: Any access other than a data-port access is accepted in the cycle it is presented. `rsp_valid` is high for exactly the one cycle after each acceptance. A successful response has `rsp_err` = 0, and a write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_be | input | 4 | Byte enables, all four must be set |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_err | output | 1 | Access rejected (partial or misaligned) |
| rsp_rdata | output | 32 | Read data |
| cfg_req | output | 1 | Downstream configuration request |
| cfg_we | output | 1 | Downstream request is a write |
| cfg_addr | output | 32 | Configuration address for the request |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_ack | input | 1 | Downstream completion |
| cfg_rdata | input | 32 | Downstream read data, valid with cfg_ack |
| io_xlate_base | output | 32 | I/O window translation base |

## Verification
Local registers answer one cycle after the accepting edge. The data port stalls for one cycle plus the downstream acknowledge delay, then answers one cycle after the acknowledge. The bench presents each request just after a falling edge and samples `req_ready` there. From the acceptance it counts exactly one edge before it checks the response. For data-port accesses it compares the measured stall length against the responder's programmed delay plus one. A reference model held in bench variables is compared against `io_xlate_base` and `rsp_valid` at every falling edge, so an output that moves a cycle early or late is reported at that cycle.

// File: rtl/pcib_pkg.sv
// Package: shared constants and types for the host bridge register slave.
// Assumes byte offsets that fit in ADDR_W bits and 32-bit data throughout.
package pcib_pkg;

    localparam int DATA_W = 32;

    // Byte offsets of the decoded registers.
    localparam int OFF_CADDR  = 'h1C0;
    localparam int OFF_MBASE  = 'h1C4;
    localparam int OFF_IOBASE = 'h1C8;
    localparam int OFF_DPORT  = 'h220;

    // Implemented-bit masks and the I/O window alignment mask.
    localparam logic [DATA_W-1:0] MBASE_MASK  = 32'hFF00_0001;
    localparam logic [DATA_W-1:0] IOBASE_MASK = 32'hFFFC_0001;
    localparam logic [DATA_W-1:0] IOWIN_MASK  = 32'hFFFC_0000;

    // Reset contents of the command and status halves of header word 1.
    localparam logic [15:0] CMD_RST  = 16'h0080;
    localparam logic [15:0] STAT_RST = 16'h0290;

    typedef enum logic [2:0] {
        RG_HDR,
        RG_CADDR,
        RG_MBASE,
        RG_IOBASE,
        RG_DPORT,
        RG_NONE
    } region_e;

endpackage

// File: rtl/pcib_decode.sv
// Module: address decoder.
// Maps a byte offset onto a register area and flags accesses that are not
// whole aligned words. Purely combinational. Assumes that 4*HDR_WORDS is a
// power of two and lies below OFF_CADDR.
module pcib_decode
    import pcib_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int HDR_WORDS = 64
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [3:0]                   be,
    output region_e                      region,
    output logic                         bad,
    output logic [$clog2(HDR_WORDS)-1:0] hdr_idx
);
    localparam int IDX_W     = $clog2(HDR_WORDS);
    localparam int HDR_BYTES = HDR_WORDS * 4;

    // Rejects partial byte enables and addresses that are not word aligned.
    always_comb bad = (be != 4'hF) || (addr[1:0] != 2'b00);

    // Selects the header word from the word-address bits.
    always_comb hdr_idx = addr[IDX_W+1:2];

    // Picks the register area from the full offset.
    always_comb begin
        if (int'(addr) < HDR_BYTES) begin
            region = RG_HDR;
        end else begin
            case (addr)
                ADDR_W'(OFF_CADDR):  region = RG_CADDR;
                ADDR_W'(OFF_MBASE):  region = RG_MBASE;
                ADDR_W'(OFF_IOBASE): region = RG_IOBASE;
                ADDR_W'(OFF_DPORT):  region = RG_DPORT;
                default:             region = RG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pcib_hdr_store.sv
// Module: local configuration header storage.
// Holds WORDS 32-bit words with one write port and one combinational read
// port. Word 0 resets to the ID pair, word 1 to the command/status
// defaults, and every other word to zero. Assumes WORDS is a power of two.
module pcib_hdr_store
    import pcib_pkg::*;
#(
    parameter int          WORDS     = 64,
    parameter logic [15:0] VENDOR_ID = 16'h1AB7,
    parameter logic [15:0] DEVICE_ID = 16'h0C21
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(WORDS)-1:0]  wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [$clog2(WORDS)-1:0]  rd_idx,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int IDX_W = $clog2(WORDS);

    function automatic logic [DATA_W-1:0] rst_word(input int i);
        case (i)
            0:       return {DEVICE_ID, VENDOR_ID};
            1:       return {STAT_RST, CMD_RST};
            default: return '0;
        endcase
    endfunction

    logic [DATA_W-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] q;

        // Resets or overwrites this one header word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= rst_word(g);
            else if (wr_en && (wr_idx == IDX_W'(g)))
                q <= wr_data;
        end

        assign words[g] = q;
    end

    // Returns the selected word.
    always_comb rd_data = words[rd_idx];

endmodule

// File: rtl/pcib_cfg_port.sv
// Module: downstream configuration request sequencer.
// A start pulse latches the direction and write data and raises the request.
// The request is held until the acknowledge, and done marks the acknowledge
// cycle. Assumes start is only given while idle.
module pcib_cfg_port
    import pcib_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_we,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              cfg_ack,
    output logic              busy,
    output logic              done,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [DATA_W-1:0] cfg_wdata
);
    // Tracks an outstanding downstream request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (start)
            busy <= 1'b1;
        else if (busy && cfg_ack)
            busy <= 1'b0;
    end

    // Latches the request contents when a request starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_we    <= 1'b0;
            cfg_wdata <= '0;
        end else if (start) begin
            cfg_we    <= start_we;
            cfg_wdata <= start_wdata;
        end
    end

    // Drives the request line and flags the completion cycle.
    always_comb begin
        cfg_req = busy;
        done    = busy && cfg_ack;
    end

endmodule

// File: rtl/pcib_regif.sv
// Module: host bridge control register slave (top).
// Decodes 32-bit register-bus accesses into the local header, the
// configuration address, memory base and I/O base registers, and an indirect
// data port that is forwarded downstream. Assumes the requester holds its
// request stable while req_ready is low.
module pcib_regif
    import pcib_pkg::*;
#(
    parameter int          ADDR_W    = 10,
    parameter int          HDR_WORDS = 64,
    parameter logic [15:0] VENDOR_ID = 16'h1AB7,
    parameter logic [15:0] DEVICE_ID = 16'h0C21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [31:0]       cfg_addr,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_ack,
    input  logic [31:0]       cfg_rdata,
    output logic [31:0]       io_xlate_base
);
    localparam int IDX_W = $clog2(HDR_WORDS);

    region_e           region;
    logic              bad;
    logic [IDX_W-1:0]  hdr_idx;
    logic              dport_hit;
    logic              accept;
    logic              wr_ok;
    logic              port_busy;
    logic              port_done;
    logic              port_start;
    logic [DATA_W-1:0] hdr_rd;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] caddr_q;
    logic [DATA_W-1:0] mbase_q;
    logic [DATA_W-1:0] iobase_q;

    pcib_decode #(
        .ADDR_W    (ADDR_W),
        .HDR_WORDS (HDR_WORDS)
    ) u_dec (
        .addr    (req_addr),
        .be      (req_be),
        .region  (region),
        .bad     (bad),
        .hdr_idx (hdr_idx)
    );

    // Qualifies the handshake: data-port accesses wait for the acknowledge.
    always_comb begin
        dport_hit  = (region == RG_DPORT) && !bad;
        req_ready  = dport_hit ? port_done : 1'b1;
        accept     = req_valid && req_ready;
        wr_ok      = accept && req_write && !bad;
        port_start = req_valid && dport_hit && !port_busy;
    end

    pcib_hdr_store #(
        .WORDS     (HDR_WORDS),
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID)
    ) u_hdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok && (region == RG_HDR)),
        .wr_idx  (hdr_idx),
        .wr_data (req_wdata),
        .rd_idx  (hdr_idx),
        .rd_data (hdr_rd)
    );

    pcib_cfg_port u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (port_start),
        .start_we    (req_write),
        .start_wdata (req_wdata),
        .cfg_ack     (cfg_ack),
        .busy        (port_busy),
        .done        (port_done),
        .cfg_req     (cfg_req),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata)
    );

    // Updates the address and base registers, applying their bit masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            caddr_q  <= '0;
            mbase_q  <= '0;
            iobase_q <= '0;
        end else if (wr_ok) begin
            case (region)
                RG_CADDR:  caddr_q  <= req_wdata;
                RG_MBASE:  mbase_q  <= req_wdata & MBASE_MASK;
                RG_IOBASE: iobase_q <= req_wdata & IOBASE_MASK;
                default:   ;
            endcase
        end
    end

    // Selects local read data; unlisted offsets read zero.
    always_comb begin
        case (region)
            RG_HDR:    rd_word = hdr_rd;
            RG_CADDR:  rd_word = caddr_q;
            RG_MBASE:  rd_word = mbase_q;
            RG_IOBASE: rd_word = iobase_q;
            RG_DPORT:  rd_word = cfg_rdata;
            default:   rd_word = '0;
        endcase
    end

    // Registers the one-cycle response to each accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_err   <= accept && bad;
            rsp_rdata <= (accept && !req_write && !bad) ? rd_word : '0;
        end
    end

    // Presents the latched address downstream and the aligned I/O window.
    always_comb begin
        cfg_addr      = caddr_q;
        io_xlate_base = iobase_q & IOWIN_MASK;
    end

endmodule

// File: rtl/pcib_regif_chk.sv
// Module: protocol checker for pcib_regif, attached to it by bind.
// Observes ports only.
module pcib_regif_chk
    import pcib_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_be,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              cfg_req,
    input logic              cfg_ack,
    input logic [31:0]       cfg_addr,
    input logic              cfg_we,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       io_xlate_base
);
    logic acc;
    logic acc_bad;
    always_comb begin
        acc     = req_valid && req_ready;
        acc_bad = acc && ((req_be != 4'hF) || (req_addr[1:0] != 2'b00));
    end

    // R10
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    // R10
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    // R10
    local_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_req && (req_addr != ADDR_W'(OFF_DPORT))) |-> req_ready);

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_we)
                                   && $stable(cfg_wdata)));

    // R6
    cfg_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_req && !cfg_ack) |-> !req_ready);

    // R5
    io_base_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && req_write) |=> $stable(io_xlate_base));

    // R9
    bad_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_bad |=> (rsp_err && !cfg_req && $stable(io_xlate_base)));

endmodule

bind pcib_regif pcib_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_be        (req_be),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .cfg_req       (cfg_req),
    .cfg_ack       (cfg_ack),
    .cfg_addr      (cfg_addr),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .io_xlate_base (io_xlate_base)
);

// File: tb/sim_pcib_regif.sv
`timescale 1ns/1ps
module sim_pcib_regif;
    localparam logic [15:0] VEN = 16'h1AB7;
    localparam logic [15:0] DEV = 16'h0C21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        cfg_req, cfg_we, cfg_ack = 1'b0;
    logic [31:0] cfg_addr, cfg_wdata, cfg_rdata = '0;
    logic [31:0] io_xlate_base;

    always #2.5 clk = ~clk;

    pcib_regif #(.VENDOR_ID(VEN), .DEVICE_ID(DEV)) u0 (.*);

    int vectors = 0, errors = 0;
    bit finished = 0;

    // Reference model state.
    logic [31:0] m_hdr [64];
    logic [31:0] m_caddr = 0, m_mbase = 0, m_iobase = 0;
    bit          m_rsp_due = 0;
    int          ack_delay = 0, ack_cnt = 0;
    logic [31:0] log_addr[$], log_wdata[$];
    bit          log_we[$];

    function automatic logic [31:0] dn_data(logic [31:0] a);
        return a ^ 32'hC3A5_0F1E;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Downstream responder: acknowledges after ack_delay cycles.
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            cfg_ack = 0; ack_cnt = 0;
        end else if (cfg_ack) begin
            cfg_ack = 0; ack_cnt = 0;
        end else if (cfg_req) begin
            if (ack_cnt >= ack_delay) begin
                cfg_ack   = 1;
                cfg_rdata = dn_data(cfg_addr);
                log_addr.push_back(cfg_addr);
                log_we.push_back(cfg_we);
                log_wdata.push_back(cfg_wdata);
            end else begin
                ack_cnt++;
            end
        end
    end

    // Per-cycle comparison of the window base and the response strobe.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R5 io_xlate_base", io_xlate_base, m_iobase & 32'hFFFC_0000);
            check("R10 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_rsp_due});
        end
    end

    task automatic access(bit we, logic [9:0] a, logic [31:0] d, logic [3:0] be, string req);
        bit          bad = (be != 4'hF) || (a[1:0] != 0);
        bit          dport = !bad && (a == 10'h220);
        logic [31:0] exp_rd = 0;
        int          stall = 0;
        int          n_log = log_addr.size();
        // Expected read data from the model.
        if (!bad && !we) begin
            if (a < 10'h100) exp_rd = m_hdr[a[7:2]];
            else if (a == 10'h1C0) exp_rd = m_caddr;
            else if (a == 10'h1C4) exp_rd = m_mbase;
            else if (a == 10'h1C8) exp_rd = m_iobase;
            else if (a == 10'h220) exp_rd = dn_data(m_caddr);
        end
        @(negedge clk);
        req_valid = 1; req_write = we; req_addr = a; req_wdata = d; req_be = be;
        #1;
        while (!req_ready) begin
            stall++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        req_valid = 0;
        m_rsp_due = 1;
        if (!bad && we) begin
            if (a < 10'h100) m_hdr[a[7:2]] = d;
            else if (a == 10'h1C0) m_caddr = d;
            else if (a == 10'h1C4) m_mbase = d & 32'hFF00_0001;
            else if (a == 10'h1C8) m_iobase = d & 32'hFFFC_0001;
        end
        @(negedge clk);
        check({req, " rsp_err"}, {31'b0, rsp_err}, {31'b0, bad});
        check({req, " rsp_rdata"}, rsp_rdata, exp_rd);
        if (dport) begin
            check("R6 stall cycles", stall, ack_delay + 1);
            check("R6 request count", log_addr.size(), n_log + 1);
            if (log_addr.size() == n_log + 1) begin
                check("R6 cfg_addr", log_addr.pop_front(), m_caddr);
                check("R6/R7 cfg_we", {31'b0, log_we.pop_front()}, {31'b0, we});
                if (we) check("R6 cfg_wdata", log_wdata.pop_front(), d);
                else void'(log_wdata.pop_front());
            end
        end else begin
            check({req, " no downstream request"}, log_addr.size(), n_log);
        end
        @(posedge clk);
        #1;
        m_rsp_due = 0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_hdr[i] = 0;
        m_hdr[0] = {DEV, VEN};
        m_hdr[1] = 32'h0290_0080;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        @(negedge clk);
        check("R10 reset rsp_valid", {31'b0, rsp_valid}, 0);
        check("R6 reset cfg_req", {31'b0, cfg_req}, 0);
        check("R5 reset io_xlate_base", io_xlate_base, 0);

        // R1 R2 R3 reset contents
        access(0, 10'h000, 0, 4'hF, "R1 id word");
        access(0, 10'h004, 0, 4'hF, "R2 cmd/status");
        access(0, 10'h008, 0, 4'hF, "R1 zero word");
        access(0, 10'h1C0, 0, 4'hF, "R3 reset");
        access(0, 10'h1C4, 0, 4'hF, "R4 reset");
        // R1 header write/read
        for (int i = 0; i < 64; i += 9)
            access(1, 10'(i * 4), 32'h1111_0000 * i + 32'h0BAD_F00D ^ i, 4'hF, "R1 write");
        access(1, 10'h0FC, 32'hDEAD_BEEF, 4'hF, "R1 write top");
        for (int i = 0; i < 64; i += 9) access(0, 10'(i * 4), 0, 4'hF, "R1 read");
        access(0, 10'h0FC, 0, 4'hF, "R1 read top");
        // R3 full 32 bits
        access(1, 10'h1C0, 32'hFFFF_FFFF, 4'hF, "R3 write");
        access(0, 10'h1C0, 0, 4'hF, "R3 read");
        // R4 masking
        access(1, 10'h1C4, 32'hFFFF_FFFF, 4'hF, "R4 write");
        access(0, 10'h1C4, 0, 4'hF, "R4 read ones");
        access(1, 10'h1C4, 32'h1234_5678, 4'hF, "R4 write");
        access(0, 10'h1C4, 0, 4'hF, "R4 read pattern");
        // R5 masking and window
        access(1, 10'h1C8, 32'hFFFF_FFFF, 4'hF, "R5 write");
        access(0, 10'h1C8, 0, 4'hF, "R5 read ones");
        access(1, 10'h1C8, 32'hABCD_EF01, 4'hF, "R5 write");
        access(0, 10'h1C8, 0, 4'hF, "R5 read pattern");
        // R8 unlisted offsets
        access(1, 10'h100, 32'h5555_5555, 4'hF, "R8 write");
        access(1, 10'h1CC, 32'h5555_5555, 4'hF, "R8 write");
        access(1, 10'h224, 32'h5555_5555, 4'hF, "R8 write");
        access(1, 10'h3FC, 32'h5555_5555, 4'hF, "R8 write");
        access(0, 10'h100, 0, 4'hF, "R8 read");
        access(0, 10'h1BC, 0, 4'hF, "R8 read");
        access(0, 10'h3FC, 0, 4'hF, "R8 read");
        access(0, 10'h1C8, 0, 4'hF, "R8 iobase untouched");
        access(0, 10'h1C0, 0, 4'hF, "R8 caddr untouched");
        // R6 R7 data port with various delays
        access(1, 10'h1C0, 32'h8000_0810, 4'hF, "R3 write");
        ack_delay = 0; access(1, 10'h220, 32'hCAFE_0001, 4'hF, "R6 port write d0");
        ack_delay = 2; access(1, 10'h220, 32'hCAFE_0002, 4'hF, "R6 port write d2");
        ack_delay = 1; access(0, 10'h220, 0, 4'hF, "R7 port read d1");
        access(1, 10'h1C0, 32'h8001_2344, 4'hF, "R3 write");
        ack_delay = 3; access(0, 10'h220, 0, 4'hF, "R7 port read d3");
        ack_delay = 0; access(0, 10'h220, 0, 4'hF, "R7 port read d0");
        // R9 rejected accesses change nothing
        access(1, 10'h1C0, 32'h0, 4'h7, "R9 partial caddr");
        access(0, 10'h1C0, 0, 4'hF, "R9 caddr unchanged");
        access(1, 10'h1CA, 32'h0, 4'hF, "R9 misaligned");
        access(1, 10'h1C8, 32'h0, 4'hE, "R9 partial iobase");
        access(0, 10'h1C8, 0, 4'hF, "R9 iobase unchanged");
        access(1, 10'h220, 32'h1, 4'h3, "R9 partial port");
        access(0, 10'h221, 0, 4'hF, "R9 misaligned port");
        access(0, 10'h006, 0, 4'hF, "R9 misaligned read");
        access(1, 10'h004, 32'h0, 4'h1, "R9 partial header");
        access(0, 10'h004, 0, 4'hF, "R9 header unchanged");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule